// File: doc/BRIEF.md
# Dual-Phase Serial Word Deframer

The deframer turns an aligned one-bit stream into parallel words of twenty bits and spreads each word onto one of two output buses. A phase flag, sampled with the last bit of a word, tells whether the word carries video or control content. Video words fill an 18-bit video bus. Control words fill a 9-bit control bus. Five of the control bits are sent three times each and are resolved by a two-of-three vote, so one corrupted copy per triple is corrected. The other four control bits are sent once. The symbol-level balance decode is treated as a pass-through.

A data-enable output shows the phase of the most recently delivered word. Only the bus that belongs to that phase is written, and the other bus keeps its old value. A realign input marks the first bit of a word and throws away any partial word. An error counter counts control triples whose copies disagree and saturates at its maximum, so a link monitor can read bit-error activity.

Top module: `wd_deframer`

## Requirements
- R1: Bits are taken only in cycles where the bit enable is high. The first bit taken becomes word bit 0. After twenty bits the word is complete. All outputs update in the second cycle after the cycle that takes the last bit, and `word_stb` is high for exactly that one cycle.
- R2: For a video word, word bits 2 to 19 drive `vid_out` bits 0 to 17. Word bits 0 and 1 have no effect on any output.
- R3: For a control word, control bit k (k = 0 to 4) is the majority of word bits 3k+1, 3k+2 and 3k+3. A single wrong copy in a triple is corrected.
- R4: For a control word, control bits 5 to 8 are copied from word bits 16 to 19 without voting. Word bit 0 has no effect on any output.
- R5: `de_out` equals the phase flag sampled together with the last bit of the most recently delivered word: 1 means video and 0 means control.
- R6: A video word leaves `ctl_out` unchanged, and a control word leaves `vid_out` unchanged.
- R7: For each control word, `err_cnt` grows by the number of triples whose three copies do not all agree. It saturates at its maximum value. Video words leave it unchanged.
- R8: When the realign input is high together with a taken bit, that bit becomes word bit 0 and any partly assembled word is discarded.
- R9: A synchronous active-high reset clears `vid_out`, `ctl_out`, `de_out`, `err_cnt` and `word_stb` to zero and restarts word assembly.
- R10: No output changes in any cycle without `word_stb`. Stream input levels in cycles where the bit enable is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Serial data bit |
| ser_en | input | 1 | Marks a cycle whose `ser_bit` is taken |
| ser_align | input | 1 | With `ser_en`, marks word bit 0 |
| ser_is_video | input | 1 | Phase flag, sampled with the last bit of a word |
| vid_out | output | 18 | Video bus |
| ctl_out | output | 9 | Control bus |
| de_out | output | 1 | Data enable: 1 video, 0 control |
| word_stb | output | 1 | One-cycle pulse when the outputs take a new word |
| err_cnt | output | 8 | Saturating count of disagreeing control triples |

## Verification
The checker watches every cycle and confirms the rules that hold without knowing the stream contents. Outputs stay still between strobes. Strobes never come in back-to-back cycles. A video word never moves the control bus or the error count, and a control word never moves the video bus. The error count only goes up, by at most five per word. The bit mapping, the vote results, the exact saturation point and realignment depend on what was sent, so only the scoreboard scenarios can show them. These scenarios use clean and corrupted triples, enable gaps, junk bits before a realign, a long run of damaged words and a reset in the middle of a run.

// File: rtl/wdf_pkg.sv
package wdf_pkg;
  parameter int WORD_W   = 20;
  parameter int VID_W    = 18;
  parameter int VID_LSB  = 2;
  parameter int VOTE_N   = 5;
  parameter int SINGLE_N = 4;
  parameter int CTL_W    = VOTE_N + SINGLE_N;
  parameter int VOTE_LSB = 1;
  parameter int SING_LSB = VOTE_LSB + 3 * VOTE_N;
  parameter int MISS_W   = $clog2(VOTE_N + 1);

  typedef struct packed {
    logic [VID_W-1:0]  vid;
    logic [CTL_W-1:0]  ctl;
    logic [MISS_W-1:0] miss;
  } dec_t;
endpackage

// File: rtl/wdf_shift_in.sv
module wdf_shift_in #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_en,
  input  logic              align,
  input  logic              phase_in,
  output logic [WORD_W-1:0] word_o,
  output logic              phase_o,
  output logic              vld_o
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     idx;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_nxt;

  always_comb begin
    idx    = align ? '0 : cnt_q;
    sh_nxt = {bit_in, sh_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      word_o  <= '0;
      phase_o <= 1'b0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (bit_en) begin
        sh_q <= sh_nxt;
        if (idx == LAST) begin
          word_o  <= sh_nxt;
          phase_o <= phase_in;
          vld_o   <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdf_vote.sv
module wdf_vote #(
  parameter int N = 5
) (
  input  logic [3*N-1:0] triples,
  output logic [N-1:0]   bits,
  output logic [N-1:0]   miss
);
  for (genvar g = 0; g < N; g++) begin : g_tri
    logic a, b, c;
    assign a       = triples[3*g];
    assign b       = triples[3*g+1];
    assign c       = triples[3*g+2];
    assign bits[g] = (a & b) | (a & c) | (b & c);
    assign miss[g] = (a ^ b) | (b ^ c);
  end
endmodule

// File: rtl/wdf_field_dec.sv
module wdf_field_dec
  import wdf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  logic [VOTE_N-1:0] voted;
  logic [VOTE_N-1:0] miss;

  wdf_vote #(.N(VOTE_N)) u_vote (
    .triples (word[VOTE_LSB +: 3*VOTE_N]),
    .bits    (voted),
    .miss    (miss)
  );

  always_comb begin
    dec.vid  = word[VID_LSB +: VID_W];
    dec.ctl  = {word[SING_LSB +: SINGLE_N], voted};
    dec.miss = '0;
    for (int i = 0; i < VOTE_N; i++) begin
      dec.miss = dec.miss + MISS_W'(miss[i]);
    end
  end
endmodule

// File: rtl/wdf_out_reg.sv
module wdf_out_reg
  import wdf_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             is_video,
  input  dec_t             dec,
  output logic [VID_W-1:0] vid_out,
  output logic [CTL_W-1:0] ctl_out,
  output logic             de_out,
  output logic             word_stb,
  output logic [ERR_W-1:0] err_cnt
);
  localparam logic [ERR_W:0] ERR_MAX = {1'b0, {ERR_W{1'b1}}};

  logic [ERR_W:0] err_sum;

  always_comb begin
    err_sum = {1'b0, err_cnt} + (ERR_W+1)'(dec.miss);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_out  <= '0;
      ctl_out  <= '0;
      de_out   <= 1'b0;
      word_stb <= 1'b0;
      err_cnt  <= '0;
    end else begin
      word_stb <= vld;
      if (vld) begin
        de_out <= is_video;
        if (is_video) begin
          vid_out <= dec.vid;
        end else begin
          ctl_out <= dec.ctl;
          err_cnt <= (err_sum > ERR_MAX) ? ERR_MAX[ERR_W-1:0] : err_sum[ERR_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/wd_deframer.sv
module wd_deframer
  import wdf_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_bit,
  input  logic             ser_en,
  input  logic             ser_align,
  input  logic             ser_is_video,
  output logic [VID_W-1:0] vid_out,
  output logic [CTL_W-1:0] ctl_out,
  output logic             de_out,
  output logic             word_stb,
  output logic [ERR_W-1:0] err_cnt
);
  logic [WORD_W-1:0] asm_word;
  logic              asm_phase;
  logic              asm_vld;
  dec_t              dec;

  wdf_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (ser_bit),
    .bit_en   (ser_en),
    .align    (ser_align),
    .phase_in (ser_is_video),
    .word_o   (asm_word),
    .phase_o  (asm_phase),
    .vld_o    (asm_vld)
  );

  wdf_field_dec u_dec (
    .word (asm_word),
    .dec  (dec)
  );

  wdf_out_reg #(.ERR_W(ERR_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .vld      (asm_vld),
    .is_video (asm_phase),
    .dec      (dec),
    .vid_out  (vid_out),
    .ctl_out  (ctl_out),
    .de_out   (de_out),
    .word_stb (word_stb),
    .err_cnt  (err_cnt)
  );
endmodule

// File: rtl/wdf_checker.sv
module wdf_checker #(
  parameter int ERR_W = 8,
  parameter int VID_W = 18,
  parameter int CTL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [VID_W-1:0] vid_out,
  input logic [CTL_W-1:0] ctl_out,
  input logic             de_out,
  input logic             word_stb,
  input logic [ERR_W-1:0] err_cnt
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) word_stb |=> !word_stb); // R1
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
    !word_stb |-> ($stable(vid_out) && $stable(ctl_out) && $stable(de_out) && $stable(err_cnt))); // R10
  AST_VID_HOLD: assert property (@(posedge clk) disable iff (rst) (word_stb && !de_out) |-> $stable(vid_out)); // R6
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst) (word_stb && de_out) |-> $stable(ctl_out)); // R6
  AST_ERR_VIDEO: assert property (@(posedge clk) disable iff (rst) (word_stb && de_out) |-> $stable(err_cnt)); // R7
  AST_ERR_MONO: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> ((err_cnt >= $past(err_cnt)) && ((err_cnt - $past(err_cnt)) <= ERR_W'(5)))); // R7
endmodule

bind wd_deframer wdf_checker #(.ERR_W(ERR_W), .VID_W(wdf_pkg::VID_W), .CTL_W(wdf_pkg::CTL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .vid_out  (vid_out),
  .ctl_out  (ctl_out),
  .de_out   (de_out),
  .word_stb (word_stb),
  .err_cnt  (err_cnt)
);

// File: tb/test_wd_deframer.sv
`timescale 1ns/100ps
module test_wd_deframer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_bit = 1'b0;
  logic        ser_en = 1'b0;
  logic        ser_align = 1'b0;
  logic        ser_is_video = 1'b0;
  logic [17:0] vid_out;
  logic [8:0]  ctl_out;
  logic        de_out;
  logic        word_stb;
  logic [7:0]  err_cnt;

  always #2.5 clk = ~clk;

  wd_deframer i_wd_deframer (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_en(ser_en), .ser_align(ser_align),
    .ser_is_video(ser_is_video), .vid_out(vid_out), .ctl_out(ctl_out), .de_out(de_out),
    .word_stb(word_stb), .err_cnt(err_cnt)
  );

  typedef struct {
    logic [17:0] vid;
    logic [8:0]  ctl;
    logic        de;
    logic [7:0]  err;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int got = 0;
  logic [17:0] m_vid = '0;
  logic [8:0]  m_ctl = '0;
  logic        m_de = 1'b0;
  int          m_err = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_ctl(input logic [14:0] tri_bits, input logic [3:0] single, input logic oh);
    return {single, tri_bits, oh};
  endfunction

  // expected result from the requirements (R2, R3, R4, R5, R7)
  task automatic model_push(input logic [19:0] w, input logic vid);
    exp_t e;
    int miss;
    if (vid) begin
      m_vid = w[19:2];
    end else begin
      miss = 0;
      for (int k = 0; k < 5; k++) begin
        int ones;
        ones = w[3*k+1] + w[3*k+2] + w[3*k+3];
        m_ctl[k] = (ones >= 2);
        if (ones == 1 || ones == 2) miss++;
      end
      m_ctl[8:5] = w[19:16];
      m_err = (m_err + miss > 255) ? 255 : m_err + miss;
    end
    m_de  = vid;
    e.vid = m_vid; e.ctl = m_ctl; e.de = m_de; e.err = 8'(m_err);
    q.push_back(e);
  endtask

  task automatic send_word(input logic [19:0] w, input logic vid, input logic align, input int gap);
    model_push(w, vid);
    for (int i = 0; i < 20; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        ser_en = 1'b0; ser_align = 1'b1; ser_bit = ~ser_bit; ser_is_video = ~vid;
      end
      @(negedge clk);
      ser_en = 1'b1;
      ser_bit = w[i];
      ser_align = align && (i == 0);
      ser_is_video = vid;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_en = 1'b0; ser_align = 1'b0; ser_bit = i[0];
    end
  endtask

  // monitor: pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (!rst && word_stb) begin
      if (q.size() == 0) begin
        check("R10 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        got++;
        check("R2/R6 vid_out", 32'(vid_out), 32'(e.vid));
        check("R3/R4/R6 ctl_out", 32'(ctl_out), 32'(e.ctl));
        check("R5 de_out", 32'(de_out), 32'(e.de));
        check("R7 err_cnt", 32'(err_cnt), 32'(e.err));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    check("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] hv; logic [8:0] hc; logic hd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 vid_out", 32'(vid_out), 0);
    check("R9 ctl_out", 32'(ctl_out), 0);
    check("R9 de_out", 32'(de_out), 0);
    check("R9 err_cnt", 32'(err_cnt), 0);
    check("R9 word_stb", 32'(word_stb), 0);

    // R1 R2 video words, overhead bits set and cleared
    send_word(20'hAAAAB, 1'b1, 1'b1, 0);
    send_word(20'h55554, 1'b1, 1'b0, 0);
    // R1 strobe timing: last bit taken at edge E, output after edge E+1
    @(negedge clk); ser_en = 1'b0;
    check("R1 no strobe one cycle after last bit", 32'(word_stb), 0);
    @(negedge clk);
    check("R1 strobe two cycles after last bit", 32'(word_stb), 1);
    // R3 R4 control words: clean, single errors, double errors, R6 holds
    send_word(mk_ctl(15'b111_000_111_000_111, 4'b1010, 1'b1), 1'b0, 1'b0, 0);
    send_word(mk_ctl(15'b110_001_011_100_101, 4'b0101, 1'b0), 1'b0, 1'b0, 0);
    send_word(mk_ctl(15'b000_000_000_000_000, 4'b1111, 1'b1), 1'b0, 1'b0, 0);
    send_word(20'h3C3C3, 1'b1, 1'b0, 0);
    send_word(mk_ctl(15'b010_100_001_110_011, 4'b0011, 1'b0), 1'b0, 1'b0, 0);
    // R10 gaps with bit enable low and junk levels
    send_word(20'h9F0E2, 1'b1, 1'b0, 2);
    send_word(mk_ctl(15'b111_111_011_111_111, 4'b1000, 1'b0), 1'b0, 1'b0, 1);
    idle(4);
    // R8 junk bits then realigned word
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); ser_en = 1'b1; ser_bit = 1'b1; ser_align = (i == 0); ser_is_video = 1'b1;
    end
    send_word(20'h12345, 1'b1, 1'b1, 0);
    idle(4);
    // R10 quiet period with toggling inputs and enable low
    hv = vid_out; hc = ctl_out; hd = de_out;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); ser_en = 1'b0; ser_bit = i[0]; ser_align = i[1]; ser_is_video = i[2];
    end
    check("R10 vid held", 32'(vid_out), 32'(hv));
    check("R10 ctl held", 32'(ctl_out), 32'(hc));
    check("R10 de held", 32'(de_out), 32'(hd));
    // R7 saturation: five misses per word
    for (int n = 0; n < 53; n++) begin
      send_word(mk_ctl(15'b001_001_001_001_001, 4'(n), 1'b0), 1'b0, 1'b0, 0);
    end
    send_word(20'hFFFFF, 1'b1, 1'b0, 0);
    idle(4);
    check("R7 saturated count", 32'(err_cnt), 255);
    // R9 reset in the middle of a partial word
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); ser_en = 1'b1; ser_bit = 1'b1; ser_align = 1'b0;
    end
    rst = 1'b1; ser_en = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_vid = '0; m_ctl = '0; m_de = 1'b0; m_err = 0;
    check("R9 vid after reset", 32'(vid_out), 0);
    check("R9 err after reset", 32'(err_cnt), 0);
    send_word(mk_ctl(15'b101_010_101_010_101, 4'b0110, 1'b1), 1'b0, 1'b0, 0);
    idle(4);
    check("R1 every word delivered", 32'(q.size()), 0);
    check("R1 word count", 32'(got), 65);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule